// File: doc/BRIEF.md
# Two-Segment I2C Channel Switch Controller

The block is an I2C target that decides which of two downstream bus segments are connected. It sees SCL and SDA as sampled inputs on a system clock that runs much faster than the bus. It pulls SDA low through an open-drain output enable. The 7-bit target address is a fixed five-bit prefix, set by a parameter with default `5'b11100`, followed by two strap pins.

A bus controller writes a control byte. The two low bits of that byte request the two channel enables. The requests are held pending and reach the enable outputs only when a STOP is seen, so a segment is never connected partway through a transaction.

Two active-low interrupt inputs, one per segment, are combined into one active-low open-drain interrupt output. They are also reported as read-only status bits in the byte returned on a read, so the controller can find the segment that is raising the request.

Top module: `i2c_chan_switch`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal {FIXED_ADDR, strap[1:0]}. On a mismatch it does not drive SDA for the rest of the transaction, and this includes the ack slots of later bytes.
- R2: Bit 0 of the address byte, which is the last one sent, selects the direction: 0 selects a write and 1 selects a read. Every data byte written after an acknowledged write address is itself acknowledged.
- R3: When several data bytes are written in one transaction, the selection that is kept is the one from the last byte.
- R4: The channel enable outputs `chan_en` keep their old value until a STOP follows the write. One STOP later they equal bits [1:0] of the last written byte. Both channels may be enabled at the same time.
- R5: `irq_n_o` is low whenever either `irq_n_i` bit is low, whether or not that channel is enabled. It is high when both inputs are high.
- R6: The read byte is laid out as follows. Bits [1:0] hold the stored selection. Bit 4 is 1 when `irq_n_i[0]` is low and bit 5 is 1 when `irq_n_i[1]` is low, both sampled at the moment the byte is loaded for sending. Bits 7, 6, 3 and 2 read as 0. Written values in bits [7:2] have no effect.
- R7: The target releases SDA in the ack slot after each byte it sends. After a not-acknowledge it sends no further bits.
- R8: A repeated START in the middle of a transaction restarts address decoding.
- R9: Driving `rst_n` low clears the stored selection and the bus state machine, and sets `chan_en` to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap | input | 2 | Low two address bits |
| irq_n_i | input | 2 | Active-low interrupt per segment |
| irq_n_o | output | 1 | Combined active-low interrupt |
| chan_en | output | 2 | Enable per downstream segment |

## Verification
The bench drives these bus patterns and checks what each one shows:
- **Wrong address vs. correct address.** This separates address matching from plain acknowledging.
- **Single-byte vs. multi-byte writes.** This shows that only the last byte is kept.
- **Enables checked before and after the STOP.** This catches enables that are applied too early.
- **Multi-byte read with the interrupt inputs changed between bytes.** This proves the status is captured when each byte is loaded, not when the read starts. The slot after the final not-acknowledge shows whether the target keeps driving.
- **Repeated START and a strap change.** These exercise address re-decoding.
- **Mid-test reset.** This shows that the stored selection is cleared.

// File: rtl/i2csw_pkg.sv
package i2csw_pkg;
  localparam int NCH     = 2;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int STRAP_W = 2;
  localparam int FIX_W   = ADDR_W - STRAP_W;
  localparam int CNT_W   = $clog2(BYTE_W) + 1;
  localparam int IRQ_LSB = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2csw_line_sampler.sv
module i2csw_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;
  logic scl_c, sda_c;

  assign scl_c = scl_sh[SYNC_STAGES-1];
  assign sda_c = sda_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_c;
      sda_p  <= sda_c;
    end
  end

  assign sda_s     = sda_c;
  assign scl_rise  = scl_c & ~scl_p;
  assign scl_fall  = ~scl_c & scl_p;
  assign start_det = scl_c & scl_p & sda_p & ~sda_c;
  assign stop_det  = scl_c & scl_p & ~sda_p & sda_c;
endmodule

// File: rtl/i2csw_target_fsm.sv
module i2csw_target_fsm
  import i2csw_pkg::*;
#(
  parameter logic [FIX_W-1:0] FIXED_ADDR = 5'b11100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rd_byte_i,
  output logic               sda_oe,
  output logic               wr_stb,
  output logic [NCH-1:0]     wr_sel
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

  tgt_state_e state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic rw_q, rw_d, ack_q, ack_d, oe_q, oe_d;
  logic addr_hit;

  assign addr_hit = (shift_q[BYTE_W-1:1] == {FIXED_ADDR, strap});

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    rw_d    = rw_q;
    ack_d   = ack_q;
    oe_d    = oe_q;
    wr_stb  = 1'b0;
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            shift_d = {shift_q[BYTE_W-2:0], sda_s};
            cnt_d   = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            if (state_q == ST_WDATA) begin
              wr_stb  = 1'b1;
              state_d = ST_WACK;
              oe_d    = 1'b1;
            end else if (addr_hit) begin
              state_d = ST_ADDR_ACK;
              rw_d    = shift_q[0];
              oe_d    = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              state_d = ST_RDATA;
              shift_d = rd_byte_i;
              oe_d    = ~rd_byte_i[BYTE_W-1];
            end else begin
              state_d = ST_WDATA;
              oe_d    = 1'b0;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            state_d = ST_WDATA;
            cnt_d   = '0;
            oe_d    = 1'b0;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == LAST_TX) begin
              state_d = ST_RACK;
              oe_d    = 1'b0;
            end else begin
              shift_d = {shift_q[BYTE_W-2:0], 1'b0};
              oe_d    = ~shift_q[BYTE_W-2];
              cnt_d   = cnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            ack_d = ~sda_s;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (ack_q) begin
              state_d = ST_RDATA;
              shift_d = rd_byte_i;
              oe_d    = ~rd_byte_i[BYTE_W-1];
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      rw_q    <= rw_d;
      ack_q   <= ack_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe = oe_q;
  assign wr_sel = shift_q[NCH-1:0];

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_ADDR && cnt_q == '0));
  assert_stop_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

// File: rtl/i2csw_ctrl.sv
module i2csw_ctrl
  import i2csw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [NCH-1:0]    wr_sel,
  input  logic              stop_det,
  input  logic [NCH-1:0]    irq_n_i,
  output logic [NCH-1:0]    chan_en,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              irq_n_o
);
  logic [NCH-1:0] sel_q, en_q, irq_s1, irq_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      en_q   <= '0;
      irq_s1 <= '1;
      irq_s2 <= '1;
    end else begin
      if (wr_stb) sel_q <= wr_sel;
      if (stop_det) en_q <= sel_q;
      irq_s1 <= irq_n_i;
      irq_s2 <= irq_s1;
    end
  end

  always_comb begin
    rd_byte = '0;
    rd_byte[NCH-1:0] = sel_q;
    for (int i = 0; i < NCH; i++) rd_byte[IRQ_LSB+i] = ~irq_s2[i];
  end

  assign chan_en = en_q;
  assign irq_n_o = &irq_n_i;

  assert_apply_at_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_en) |-> $past(stop_det));
  assert_last_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> rd_byte[NCH-1:0] == $past(wr_sel));
endmodule

// File: rtl/i2c_chan_switch.sv
module i2c_chan_switch
  import i2csw_pkg::*;
#(
  parameter logic [FIX_W-1:0] FIXED_ADDR = 5'b11100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  input  logic [NCH-1:0]     irq_n_i,
  output logic               irq_n_o,
  output logic [NCH-1:0]     chan_en
);
  logic [1:0] rst_sync;
  logic rst_int_n;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det, wr_stb;
  logic [NCH-1:0] wr_sel;
  logic [BYTE_W-1:0] rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  i2csw_line_sampler #(.SYNC_STAGES(2)) u_smp (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  i2csw_target_fsm #(.FIXED_ADDR(FIXED_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .strap(strap), .rd_byte_i(rd_byte), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_sel(wr_sel));

  i2csw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .wr_stb(wr_stb), .wr_sel(wr_sel),
    .stop_det(stop_det), .irq_n_i(irq_n_i), .chan_en(chan_en),
    .rd_byte(rd_byte), .irq_n_o(irq_n_o));
endmodule

// File: tb/i2c_chan_switch_test.sv
`timescale 1ns/1ps
module i2c_chan_switch_test;
  localparam int Q = 250;
  logic clk = 1'b0;
  logic rst_n, scl, sda_drv_low, irq_n_o, sda_oe;
  logic [1:0] strap, irq_n_i, chan_en;
  wire sda_line = ~(sda_drv_low | sda_oe);
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] act_byte;
  event rd_done;

  always #5 clk = ~clk;

  i2c_chan_switch uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(strap), .irq_n_i(irq_n_i), .irq_n_o(irq_n_o), .chan_en(chan_en));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_drv_low = 0; #Q; scl = 1; #Q; sda_drv_low = 1; #Q; scl = 0; #Q;
  endtask
  task automatic bus_stop();
    sda_drv_low = 1; #Q; scl = 1; #Q; sda_drv_low = 0; #Q;
  endtask
  task automatic put_bit(input logic b);
    sda_drv_low = ~b; #Q; scl = 1; #(2*Q); scl = 0; #Q;
  endtask
  task automatic get_bit(output logic b);
    sda_drv_low = 0; #Q; scl = 1; #Q; b = sda_line; #Q; scl = 0; #Q;
  endtask
  task automatic put_byte(input logic [7:0] d, output logic ack_bit);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(ack_bit);
  endtask
  task automatic get_byte();
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); act_byte[i] = b; end
    -> rd_done;
  endtask
  task automatic expect_rd(input logic [7:0] e, input string req);
    exp_q.push_back(e); tag_q.push_back(req);
  endtask

  // scoreboard monitor
  initial forever begin
    @(rd_done);
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R6: actual %02h expected none", act_byte);
    end else chk(tag_q.pop_front(), act_byte, exp_q.pop_front());
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic a;
    rst_n = 0; scl = 1; sda_drv_low = 0; strap = 2'b10; irq_n_i = 2'b11;
    #100; rst_n = 1; #200;
    chk("R9 reset chan_en", {6'd0, chan_en}, 8'h00);
    chk("R9 reset sda", {7'd0, sda_line}, 8'h01);
    chk("R5 idle irq", {7'd0, irq_n_o}, 8'h01);

    // wrong address: 1110011
    bus_start(); put_byte(8'hE6, a); chk("R1 mismatch nack", {7'd0, a}, 8'h01);
    put_byte(8'h03, a); chk("R1 no data ack", {7'd0, a}, 8'h01);
    bus_stop(); #100; chk("R1 no enable", {6'd0, chan_en}, 8'h00);

    // write 0x03
    bus_start(); put_byte(8'hE4, a); chk("R1 addr ack", {7'd0, a}, 8'h00);
    put_byte(8'h03, a); chk("R2 write ack", {7'd0, a}, 8'h00);
    #100; chk("R4 pending before stop", {6'd0, chan_en}, 8'h00);
    bus_stop(); #100; chk("R4 applied at stop", {6'd0, chan_en}, 8'h03);

    // multi-byte write
    bus_start(); put_byte(8'hE4, a); put_byte(8'h01, a); put_byte(8'h02, a);
    bus_stop(); #100; chk("R3 last byte kept", {6'd0, chan_en}, 8'h02);

    // upper bits ignored, then read
    bus_start(); put_byte(8'hE4, a); put_byte(8'hF1, a);
    bus_stop(); #100; chk("R6 upper write ignored", {6'd0, chan_en}, 8'h01);
    bus_start(); put_byte(8'hE5, a); chk("R2 read addr ack", {7'd0, a}, 8'h00);
    expect_rd(8'h01, "R6 read no irq"); get_byte(); put_bit(1'b1); bus_stop();

    // interrupt on disabled channel 1
    irq_n_i = 2'b01; #100;
    chk("R5 irq on disabled ch", {7'd0, irq_n_o}, 8'h00);
    bus_start(); put_byte(8'hE5, a);
    expect_rd(8'h21, "R6 irq1 status"); get_byte();
    irq_n_i = 2'b00; #Q;
    put_bit(1'b0);
    expect_rd(8'h31, "R6 live capture 2nd byte"); get_byte();
    get_bit(a); chk("R7 released in ack slot", {7'd0, a}, 8'h01);
    get_bit(a); chk("R7 silent after nack", {7'd0, a}, 8'h01);
    bus_stop();

    // repeated start
    bus_start(); put_byte(8'hE4, a); put_byte(8'h02, a);
    bus_start(); put_byte(8'hE5, a); chk("R8 re-decode ack", {7'd0, a}, 8'h00);
    expect_rd(8'h32, "R8 read after restart"); get_byte(); put_bit(1'b1);
    bus_stop(); #100; chk("R8 enable after restart", {6'd0, chan_en}, 8'h02);

    // strap change
    strap = 2'b01;
    bus_start(); put_byte(8'hE4, a); chk("R1 old strap nack", {7'd0, a}, 8'h01);
    bus_stop();
    bus_start(); put_byte(8'hE2, a); chk("R1 new strap ack", {7'd0, a}, 8'h00);
    put_byte(8'h03, a); bus_stop(); #100;
    chk("R4 both enabled", {6'd0, chan_en}, 8'h03);

    // reset mid-run
    rst_n = 0; #52;
    chk("R9 async clear", {6'd0, chan_en}, 8'h00);
    rst_n = 1; #200;
    bus_start(); put_byte(8'hE3, a);
    expect_rd(8'h30, "R9 selection cleared"); get_byte(); put_bit(1'b1); bus_stop();
    irq_n_i = 2'b11; #100;
    chk("R5 irq released", {7'd0, irq_n_o}, 8'h01);

    #100;
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R6: actual %0d pending expected 0", exp_q.size());
    end
    summary();
  end
endmodule